// File: doc/BRIEF.md
# Two-Master AXI4 Write-Path Merge

This block joins the write side of two AXI4 masters onto a single slave port. A round-robin arbiter picks one of the two address requests and forwards it to the slave. The block holds that choice until the slave accepts the address. Each accepted address pushes the index of its source master into a small order queue. AXI4 write data carries no ID, so the block uses that queue to decide whose data may reach the slave. Only the master at the head of the queue is connected to the slave's data channel. The connection moves to the next master only after the last beat of the current burst has been accepted.

When a burst finishes, the owning master's index moves into a second queue that tracks responses. Each response the slave returns goes to the master at the head of that queue. A master may raise its write data before its address is granted. That data simply waits, with ready held low, until its turn comes. The block sits between the masters and a slave that may accept several addresses before any data arrives.

Top module: `axi_wr_merge`

## Requirements
- R1: While `rst` is high, `s_awvalid` and `m_awready` stay low. One clock after a reset edge, `s_wvalid`, `m_wready`, `m_bvalid` and `s_bready` are all low, and both queues are empty.
- R2: `s_awvalid` is high when a grant is being held or any master raises `m_awvalid` while the order queue has room. The payload shown is the chosen master's. When both masters request, the chosen master is the one that did not win the last accepted address; the first contest after reset goes to master 0 (bit 0). `m_awready[i]` equals `s_awready` for the chosen master i and is 0 for the other master.
- R3: Once `s_awvalid` is shown without `s_awready`, the same master stays chosen, and `s_awaddr`/`s_awlen` stay unchanged until the handshake.
- R4: When DEPTH accepted addresses still have bursts that have not completed, `s_awvalid` and both `m_awready` bits stay low.
- R5: Write data is forwarded only from the master at the head of the order queue. That master's `m_wready` follows `s_wready`, and the other master's `m_wready` is 0.
- R6: Data bursts reach the slave whole, in the order their addresses were accepted, with no beats from the other master in between. The queue advances when a beat with `s_wlast` completes.
- R7: A master that raises `m_wvalid` before any of its addresses has been accepted sees `m_wready` low, and its data does not reach the slave.
- R8: Every slave response is routed, with `m_bresp`, to the master whose completed burst is the oldest one not yet answered. `s_bready` follows that master's `m_bready`, and every other `m_bvalid` bit is 0.
- R9: While DEPTH completed bursts are waiting for responses, `s_wvalid` and both `m_wready` bits stay low.

Top module port list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_awvalid | input | 2 | Address valid, one bit per master |
| m_awready | output | 2 | Address ready, one bit per master |
| m_awaddr | input | 2 x ADDR_W | Write address per master |
| m_awlen | input | 2 x 8 | Burst length minus one per master |
| m_wvalid | input | 2 | Data valid per master |
| m_wready | output | 2 | Data ready per master |
| m_wdata | input | 2 x DATA_W | Write data per master |
| m_wstrb | input | 2 x DATA_W/8 | Byte enables per master |
| m_wlast | input | 2 | Last beat of burst per master |
| m_bvalid | output | 2 | Response valid per master |
| m_bready | input | 2 | Response ready per master |
| m_bresp | output | 2 x 2 | Response code per master |
| s_awvalid | output | 1 | Address valid toward slave |
| s_awready | input | 1 | Address ready from slave |
| s_awaddr | output | ADDR_W | Address toward slave |
| s_awlen | output | 8 | Burst length minus one toward slave |
| s_wvalid | output | 1 | Data valid toward slave |
| s_wready | input | 1 | Data ready from slave |
| s_wdata | output | DATA_W | Data toward slave |
| s_wstrb | output | DATA_W/8 | Byte enables toward slave |
| s_wlast | output | 1 | Last beat toward slave |
| s_bvalid | input | 1 | Response valid from slave |
| s_bready | output | 1 | Response ready toward slave |
| s_bresp | input | 2 | Response code from slave |

## Verification
The merge is first driven with both masters and the slave always ready. That shows the strict alternation of the round-robin grant and ordered bursts with no stalls. A phase with random readiness on every channel then separates a held grant from a re-arbitrated one, and shows how uneven burst lengths interleave at the address level while staying whole at the data level.

Two phases block one side for a while. Blocking slave data fills the order queue and shows the address stall. Withholding slave responses fills the response queue and shows the data stall. A phase with slow address acceptance and eager data shows that early data waits and is never misattributed to the master whose address came first.

// File: rtl/axi_wmerge_pkg.sv
package axi_wmerge_pkg;

    localparam int LEN_W  = 8;
    localparam int RESP_W = 2;

    typedef enum logic [0:0] {
        SRC_M0 = 1'b0,
        SRC_M1 = 1'b1
    } src_e;

    // Round-robin choice: on a tie the master that did not win last time goes.
    function automatic src_e rr_pick(input logic [1:0] req, input src_e last);
        if (req == 2'b11)
            return (last == SRC_M0) ? SRC_M1 : SRC_M0;
        else if (req[1])
            return SRC_M1;
        else
            return SRC_M0;
    endfunction

endpackage

// File: rtl/wm_src_fifo.sv
module wm_src_fifo
    import axi_wmerge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  src_e din,
    input  logic pop,
    output src_e dout,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    src_e          slots [DEPTH];
    logic [PW:0]   wptr;
    logic [PW:0]   rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) wptr <= wptr + 1'b1;
            if (pop && !empty) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) slots[wptr[PW-1:0]] <= din;
    end

    assign dout  = slots[rptr[PW-1:0]];
    assign empty = (wptr == rptr);
    assign full  = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);

endmodule

// File: rtl/wm_aw_arb.sv
module wm_aw_arb
    import axi_wmerge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       taken,
    output logic       valid,
    output src_e       gnt
);
    logic held;
    src_e held_src;
    src_e last_win;

    always_comb begin
        valid = held | (|req);
        gnt   = held ? held_src : rr_pick(req, last_win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= 1'b0;
            held_src <= SRC_M0;
            last_win <= SRC_M1;
        end else if (valid && taken) begin
            held     <= 1'b0;
            last_win <= gnt;
        end else if (valid) begin
            held     <= 1'b1;
            held_src <= gnt;
        end
    end

endmodule

// File: rtl/axi_wr_merge.sv
module axi_wr_merge
    import axi_wmerge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    m_awvalid,
    output logic [1:0]                    m_awready,
    input  logic [1:0][ADDR_W-1:0]        m_awaddr,
    input  logic [1:0][LEN_W-1:0]         m_awlen,
    input  logic [1:0]                    m_wvalid,
    output logic [1:0]                    m_wready,
    input  logic [1:0][DATA_W-1:0]        m_wdata,
    input  logic [1:0][DATA_W/8-1:0]      m_wstrb,
    input  logic [1:0]                    m_wlast,
    output logic [1:0]                    m_bvalid,
    input  logic [1:0]                    m_bready,
    output logic [1:0][RESP_W-1:0]        m_bresp,
    output logic                          s_awvalid,
    input  logic                          s_awready,
    output logic [ADDR_W-1:0]             s_awaddr,
    output logic [LEN_W-1:0]              s_awlen,
    output logic                          s_wvalid,
    input  logic                          s_wready,
    output logic [DATA_W-1:0]             s_wdata,
    output logic [DATA_W/8-1:0]           s_wstrb,
    output logic                          s_wlast,
    input  logic                          s_bvalid,
    output logic                          s_bready,
    input  logic [RESP_W-1:0]             s_bresp
);
    localparam int NUM_M = 2;

    logic [1:0] aw_req;
    logic       arb_valid;
    src_e       aw_src;
    logic       aw_idx;
    logic       aw_fire;

    logic       ord_empty, ord_full;
    src_e       ord_head;
    logic       w_idx;
    logic       w_open;
    logic       w_done;

    logic       bq_empty, bq_full;
    src_e       bq_head;
    logic       b_idx;
    logic       b_done;

    // Address path: arbitration, stalled while the order queue is full.
    assign aw_req = m_awvalid & {NUM_M{~ord_full}};

    wm_aw_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (aw_req),
        .taken (s_awready),
        .valid (arb_valid),
        .gnt   (aw_src)
    );

    assign aw_idx    = aw_src;
    assign s_awvalid = arb_valid & ~rst;
    assign s_awaddr  = m_awaddr[aw_idx];
    assign s_awlen   = m_awlen[aw_idx];
    assign aw_fire   = s_awvalid & s_awready;

    wm_src_fifo #(.DEPTH(DEPTH)) u_order_q (
        .clk   (clk),
        .rst   (rst),
        .push  (aw_fire),
        .din   (aw_src),
        .pop   (w_done),
        .dout  (ord_head),
        .empty (ord_empty),
        .full  (ord_full)
    );

    // Data path: only the head of the order queue is connected.
    assign w_idx    = ord_head;
    assign w_open   = ~ord_empty & ~bq_full;
    assign s_wvalid = w_open & m_wvalid[w_idx];
    assign s_wdata  = m_wdata[w_idx];
    assign s_wstrb  = m_wstrb[w_idx];
    assign s_wlast  = m_wlast[w_idx];
    assign w_done   = s_wvalid & s_wready & s_wlast;

    wm_src_fifo #(.DEPTH(DEPTH)) u_resp_q (
        .clk   (clk),
        .rst   (rst),
        .push  (w_done),
        .din   (ord_head),
        .pop   (b_done),
        .dout  (bq_head),
        .empty (bq_empty),
        .full  (bq_full)
    );

    // Response path: routed to the oldest completed burst's owner.
    assign b_idx    = bq_head;
    assign s_bready = ~bq_empty & m_bready[b_idx];
    assign b_done   = s_bvalid & s_bready;

    for (genvar i = 0; i < NUM_M; i++) begin : g_port
        assign m_awready[i] = aw_fire & (aw_idx == 1'(i));
        assign m_wready[i]  = w_open & s_wready & (w_idx == 1'(i));
        assign m_bvalid[i]  = ~bq_empty & s_bvalid & (b_idx == 1'(i));
        assign m_bresp[i]   = s_bresp;
    end

endmodule

// File: rtl/axi_wr_merge_chk.sv
module axi_wr_merge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic [ADDR_W-1:0] s_awaddr,
    input logic [7:0]        s_awlen,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic [DATA_W-1:0] s_wdata,
    input logic              s_wlast,
    input logic [1:0]        m_wready,
    input logic [1:0]        m_bvalid,
    input logic              s_bvalid,
    input logic              s_bready
);
    localparam int CW = $clog2(DEPTH) + 2;

    // Addresses accepted whose bursts have not yet completed.
    logic [CW-1:0] open_cnt;
    always_ff @(posedge clk) begin
        if (rst) open_cnt <= '0;
        else open_cnt <= open_cnt + CW'(s_awvalid && s_awready)
                                  - CW'(s_wvalid && s_wready && s_wlast);
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !s_wvalid && !s_bready && (m_bvalid == 2'b00) && (m_wready == 2'b00));

    // R3
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_awvalid && !s_awready |=> s_awvalid && $stable(s_awaddr) && $stable(s_awlen));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (open_cnt >= CW'(DEPTH)) |-> !s_awvalid);

    // R5
    one_wready_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_wready));

    // R7
    no_orphan_data_chk: assert property (@(posedge clk) disable iff (rst)
        (open_cnt == '0) |-> !s_wvalid && (m_wready == 2'b00));

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_wvalid && !s_wready |=> s_wvalid && $stable(s_wdata) && $stable(s_wlast));

    // R8
    one_bvalid_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_bvalid) && ((m_bvalid != 2'b00) -> s_bvalid));

endmodule

bind axi_wr_merge axi_wr_merge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) chk_i (.*);

// File: tb/axi_wr_merge_tb_top.sv
module axi_wr_merge_tb_top;
    import axi_wmerge_pkg::*;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int NB = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0]           m_awvalid, m_awready, m_wvalid, m_wready, m_wlast;
    logic [1:0]           m_bvalid, m_bready;
    logic [1:0][AW-1:0]   m_awaddr;
    logic [1:0][7:0]      m_awlen;
    logic [1:0][DW-1:0]   m_wdata;
    logic [1:0][DW/8-1:0] m_wstrb;
    logic [1:0][1:0]      m_bresp;
    logic                 s_awvalid, s_awready, s_wvalid, s_wready, s_wlast;
    logic                 s_bvalid, s_bready;
    logic [AW-1:0]        s_awaddr;
    logic [7:0]           s_awlen;
    logic [DW-1:0]        s_wdata;
    logic [DW/8-1:0]      s_wstrb;
    logic [1:0]           s_bresp;

    axi_wr_merge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] rng = 32'h2545_f491;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit roll(input int pct);
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return (rng % 100) < pct;
    endfunction

    function automatic int lenf(input int m, input int b);
        return (m * 3 + b * 5) % 4;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Bench state
    int aw_i[2], w_b[2], w_beat[2], b_cnt[2];
    int owed, bseq;
    int ordq[$], bq[$];
    logic [AW-1:0] srcq[$];
    bit lk;
    int lkg, lw;
    bit saw_full, saw_bfull, saw_early, saw_hold;
    bit r_maw[2], r_mw[2], r_mb[2], r_swl, r_sb, r_saw, r_sw;
    bit e_aw, e_wl, e_b;
    int e_g, e_h;

    task automatic do_reset();
        rst = 1'b1;
        m_awvalid = '0; m_wvalid = '0; m_wlast = '0; m_bready = '0;
        m_awaddr = '0; m_awlen = '0; m_wdata = '0; m_wstrb = '0;
        s_awready = 0; s_wready = 0; s_bvalid = 0; s_bresp = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet outputs under reset
        chk(!s_awvalid && m_awready == 0, "R1 aw outputs", {m_awready, s_awvalid}, 0);
        chk(!s_wvalid && m_wready == 0, "R1 w outputs", {m_wready, s_wvalid}, 0);
        chk(m_bvalid == 0 && !s_bready, "R1 b outputs", {m_bvalid, s_bready}, 0);
        ordq.delete(); bq.delete(); srcq.delete();
        lk = 0; lkg = 0; lw = 1; owed = 0; bseq = 0;
        for (int m = 0; m < 2; m++) begin
            aw_i[m] = 0; w_b[m] = 0; w_beat[m] = 0; b_cnt[m] = 0;
            r_maw[m] = 0; r_mw[m] = 0; r_mb[m] = 0;
        end
        r_swl = 0; r_sb = 0; r_saw = 0; r_sw = 0; e_aw = 0; e_wl = 0; e_b = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_phase(input int awr, input int wr, input int saw, input int sw,
                             input int br, input int mbr, input int wblk, input int bblk);
        int pc;
        pc = 0;
        while ((b_cnt[0] < NB || b_cnt[1] < NB) && pc < 6000) begin
            @(negedge clk);
            pc++;
            // apply handshakes of previous cycle
            for (int m = 0; m < 2; m++) begin
                if (r_maw[m]) begin m_awvalid[m] = 0; aw_i[m]++; end
                if (r_mw[m]) begin
                    m_wvalid[m] = 0;
                    if (w_beat[m] == lenf(m, w_b[m])) begin w_beat[m] = 0; w_b[m]++; end
                    else w_beat[m]++;
                end
                if (r_mb[m]) b_cnt[m]++;
            end
            if (r_swl) owed++;
            if (r_sb) begin s_bvalid = 0; owed--; bseq++; end
            // reference model state update
            if (e_aw) begin ordq.push_back(e_g); lw = e_g; lk = 0; end
            else if (e_g >= 0) begin lk = 1; lkg = e_g; end
            if (e_wl) begin void'(ordq.pop_front()); bq.push_back(e_h); end
            if (e_b) void'(bq.pop_front());
            // drive new stimulus
            for (int m = 0; m < 2; m++) begin
                if (!m_awvalid[m] && aw_i[m] < NB && roll(awr)) begin
                    m_awvalid[m] = 1;
                    m_awaddr[m] = AW'((m << 16) | (aw_i[m] << 4));
                    m_awlen[m] = 8'(lenf(m, aw_i[m]));
                end
                if (!m_wvalid[m] && w_b[m] < NB && roll(wr)) begin
                    m_wvalid[m] = 1;
                    m_wdata[m] = DW'((m << 24) | (w_b[m] << 8) | w_beat[m]);
                    m_wstrb[m] = 4'hf;
                    m_wlast[m] = (w_beat[m] == lenf(m, w_b[m]));
                end
                m_bready[m] = roll(mbr);
            end
            s_awready = roll(saw);
            s_wready = (pc > wblk) && roll(sw);
            if (!s_bvalid && owed > 0 && pc > bblk && roll(br)) begin
                s_bvalid = 1; s_bresp = 2'(bseq);
            end
            #1;
            compare();
        end
        chk(b_cnt[0] == NB && b_cnt[1] == NB, "R8 all responses delivered", {b_cnt[1], b_cnt[0]}, {NB, NB});
    endtask

    task automatic compare();
        bit full, r0, r1, ev, wopen, ewv, bo;
        int g, h, bh;
        full = ordq.size() >= DEPTH;
        r0 = m_awvalid[0] && !full;
        r1 = m_awvalid[1] && !full;
        ev = lk || r0 || r1;
        g = lk ? lkg : ((r0 && r1) ? 1 - lw : (r1 ? 1 : 0));
        if (full && m_awvalid != 0) saw_full = 1;
        if (lk) saw_hold = 1;
        chk(s_awvalid == ev, full ? "R4 s_awvalid" : "R2 s_awvalid", s_awvalid, ev);
        if (ev) begin
            chk(s_awaddr == m_awaddr[g] && s_awlen == m_awlen[g],
                lk ? "R3 held address" : "R2 granted address", s_awaddr, m_awaddr[g]);
            chk(m_awready == (s_awready ? 2'(1 << g) : 2'b00), "R2 m_awready", m_awready,
                s_awready ? 2'(1 << g) : 2'b00);
        end else
            chk(m_awready == 0, full ? "R4 m_awready" : "R2 m_awready", m_awready, 0);
        // data channel
        wopen = ordq.size() > 0 && bq.size() < DEPTH;
        h = (ordq.size() > 0) ? ordq[0] : 0;
        if (ordq.size() > 0 && bq.size() >= DEPTH) saw_bfull = 1;
        ewv = wopen && m_wvalid[h];
        chk(s_wvalid == ewv, (bq.size() >= DEPTH) ? "R9 s_wvalid" : "R5 s_wvalid", s_wvalid, ewv);
        if (ewv) chk(s_wdata == m_wdata[h] && s_wlast == m_wlast[h], "R5 head data", s_wdata, m_wdata[h]);
        chk(m_wready == ((wopen && s_wready) ? 2'(1 << h) : 2'b00),
            (bq.size() >= DEPTH) ? "R9 m_wready" : "R5 m_wready", m_wready,
            (wopen && s_wready) ? 2'(1 << h) : 2'b00);
        for (int m = 0; m < 2; m++)
            if (m_wvalid[m] && w_b[m] >= aw_i[m]) begin
                saw_early = 1;
                chk(!m_wready[m], "R7 early data held", m_wready[m], 0);
            end
        // response channel
        bo = bq.size() > 0;
        bh = bo ? bq[0] : 0;
        chk(m_bvalid == ((bo && s_bvalid) ? 2'(1 << bh) : 2'b00), "R8 m_bvalid", m_bvalid,
            (bo && s_bvalid) ? 2'(1 << bh) : 2'b00);
        chk(s_bready == (bo && m_bready[bh]), "R8 s_bready", s_bready, bo && m_bready[bh]);
        if (bo && s_bvalid) chk(m_bresp[bh] == s_bresp, "R8 m_bresp", m_bresp[bh], s_bresp);
        // slave-side order scoreboard
        if (s_awvalid && s_awready) srcq.push_back(s_awaddr);
        if (s_wvalid && s_wready) begin
            if (srcq.size() == 0)
                chk(0, "R6 data without address", s_wdata, 0);
            else begin
                chk(s_wdata[24] == srcq[0][16] && s_wdata[15:8] == srcq[0][11:4],
                    "R6 burst order", s_wdata, srcq[0]);
                if (s_wlast) void'(srcq.pop_front());
            end
        end
        // record handshakes
        for (int m = 0; m < 2; m++) begin
            r_maw[m] = m_awvalid[m] && m_awready[m];
            r_mw[m]  = m_wvalid[m] && m_wready[m];
            r_mb[m]  = m_bvalid[m] && m_bready[m];
        end
        r_swl = s_wvalid && s_wready && s_wlast;
        r_sb  = s_bvalid && s_bready;
        e_aw = ev && s_awready;
        e_g  = ev ? g : -1;
        e_wl = ewv && s_wready && m_wlast[h];
        e_h  = h;
        e_b  = bo && s_bvalid && m_bready[bh];
    endtask

    initial begin
        saw_full = 0; saw_bfull = 0; saw_early = 0; saw_hold = 0;
        do_reset();
        run_phase(100, 100, 100, 100, 100, 100, 0, 0);
        do_reset();
        run_phase(60, 70, 50, 60, 50, 70, 0, 0);
        do_reset();
        run_phase(90, 80, 100, 80, 80, 80, 60, 0);
        do_reset();
        run_phase(90, 90, 90, 100, 90, 90, 0, 80);
        do_reset();
        run_phase(25, 100, 30, 70, 60, 60, 0, 0);
        chk(saw_full, "R4 order queue reached full", saw_full, 1);
        chk(saw_bfull, "R9 response queue reached full", saw_bfull, 1);
        chk(saw_early, "R7 early data observed", saw_early, 1);
        chk(saw_hold, "R3 held grant observed", saw_hold, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule